// File: doc/BRIEF.md
# Serial-Loaded Configuration Shift Array

This block keeps a bank of 54 configuration words that a downstream routing fabric consumes in parallel. Software cannot address any single word. It loads the bank by writing words one at a time to a data-in register. Each accepted write pushes the new word into the lowest position and moves every older word up by one. The word pushed out of the top position is caught in a data-out holding register. Software can therefore read back the previous contents by writing the whole bank a second time and reading data-out after each write.

A control register carries an output enable, a write-counter clear bit, a read-only fill count and a read-only full flag. Once 54 words have been accepted, the bank locks and ignores further data-in writes until software unlocks it. The configuration vector handed to the consumer is forced to all zeros whenever the enable is low, so the fabric sees no partial setup while loading is in progress.

The register interface is synchronous. It has separate write and read strobes, each with its own 2-bit address. Write data and read data are 32 bits wide.

Top module: `cfg_shift_array`

## Requirements
- R1: After reset, the enable bit is 0, the write-counter clear bit is 0, the fill count is 0, the full flag is 0, every entry is 0, the data-out holding register is 0 and `cfgOut` is all zeros.
- R2: An accepted write to address 1 (data-in) places the write data at position 1 (`cfgOut` bits [31:0]). Every older entry at position k moves to position k+1. Position p occupies bits [32p-1 : 32p-32].
- R3: Each accepted data-in write raises the fill count by 1. The count saturates at 54.
- R4: A write to address 0 (control) with bit 1 set clears the fill count to 0 and clears the full flag.
- R5: The data-in write that brings the fill count from 53 to 54 sets the full flag. While the flag is set, data-in writes change neither the entries, the fill count nor the data-out register.
- R6: A control write with bit 1 clear also clears the full flag, but leaves the fill count unchanged. Data-in writes are then accepted again while the count stays at 54, and the full flag stays clear.
- R7: Control bit 0 is the enable. While it is 0, `cfgOut` is all zeros. While it is 1, `cfgOut` shows the stored entries.
- R8: On each accepted data-in write, the entry leaving position 54 is captured into the data-out register. If the bank is rewritten with a data-out read after each write, the reads return the first pass's words in the order they were first written.
- R9: A read strobe updates `rdData` at the next clock edge. The value comes from the state held before that edge. Address 0 reads the control layout: bit 0 enable, bit 1 clear bit as last written, bit 2 full, bits 13:8 fill count, all other bits 0. Address 2 reads data-out. Addresses 1 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 2 | Write address: 0 control, 1 data-in |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 2 | Read address: 0 control, 2 data-out |
| rdData | output | 32 | Registered read data |
| cfgOut | output | 1728 | All 54 entries, gated by the enable, position 1 in the low bits |

## Verification
A register read and a data-in write can land in the same cycle. The read must then report the state from before the write. The bench sends the 54th data-in write together with a control read. That read must show a count of 53 with the full flag clear, and a read issued in the following cycle must show 54 with the flag set. During the second pass, each data-in write is followed by a data-out read whose expected value is the word written in the same slot of the first pass. A scoreboard queue checks both orderings.

// File: rtl/cfg_shift_pkg.sv
package cfg_shift_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DIN  = 2'd1;
  localparam logic [1:0] ADDR_DOUT = 2'd2;

  localparam int BIT_EN   = 0;
  localparam int BIT_CLR  = 1;
  localparam int BIT_FULL = 2;
  localparam int CNT_LSB  = 8;

  typedef struct packed {
    logic shift;
    logic arrayEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/cfg_array_datapath.sv
module cfg_array_datapath
  import cfg_shift_pkg::*;
#(
  parameter int DEPTH = 54,
  parameter int WIDTH = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strobes,
  input  logic [WIDTH-1:0]       dataIn,
  output logic [WIDTH-1:0]       dataOut,
  output logic [DEPTH*WIDTH-1:0] cfgOut
);
  logic [WIDTH-1:0] chain [DEPTH];
  logic [WIDTH-1:0] outHold;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[k] <= '0;
        else if (strobes.shift) chain[k] <= dataIn;
    end else begin : g_rest
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[k] <= '0;
        else if (strobes.shift) chain[k] <= chain[k-1];
    end
    assign cfgOut[k*WIDTH +: WIDTH] = strobes.arrayEn ? chain[k] : '0;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) outHold <= '0;
    else if (strobes.shift) outHold <= chain[DEPTH-1];

  assign dataOut = outHold;

  // R2: bottom position takes the written word
  a_r2_bottom_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |=> chain[0] == $past(dataIn));
  // R8: top entry moves into the holding register
  a_r8_capture_top: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |=> outHold == $past(chain[DEPTH-1]));
  // R5: without an accepted write the holding register keeps its value
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.shift |=> $stable(outHold));
endmodule

// File: rtl/cfg_array_ctrl.sv
module cfg_array_ctrl
  import cfg_shift_pkg::*;
#(
  parameter int DEPTH = 54,
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  input  logic [1:0]       rdAddr,
  input  logic [WIDTH-1:0] dataOut,
  output logic [WIDTH-1:0] rdData,
  output ctrlStrobes_t     strobes
);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);

  logic             enable, clrBit, full;
  logic [CNT_W-1:0] fillCnt;
  logic             ctrlWr, dinWr, accept;
  logic [WIDTH-1:0] ctrlView;

  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);
  assign dinWr  = wrEn && (wrAddr == ADDR_DIN);
  assign accept = dinWr && !full;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      enable  <= 1'b0;
      clrBit  <= 1'b0;
      full    <= 1'b0;
      fillCnt <= '0;
    end else if (ctrlWr) begin
      enable <= wrData[BIT_EN];
      clrBit <= wrData[BIT_CLR];
      full   <= 1'b0;
      if (wrData[BIT_CLR]) fillCnt <= '0;
    end else if (accept) begin
      if (fillCnt != CNT_MAX) fillCnt <= fillCnt + 1'b1;
      if (fillCnt == CNT_LAST) full <= 1'b1;
    end

  always_comb begin
    ctrlView                   = '0;
    ctrlView[BIT_EN]           = enable;
    ctrlView[BIT_CLR]          = clrBit;
    ctrlView[BIT_FULL]         = full;
    ctrlView[CNT_LSB +: CNT_W] = fillCnt;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) rdData <= '0;
    else if (rdEn) begin
      case (rdAddr)
        ADDR_CTRL: rdData <= ctrlView;
        ADDR_DOUT: rdData <= dataOut;
        default:   rdData <= '0;
      endcase
    end

  assign strobes.shift   = accept;
  assign strobes.arrayEn = enable;

  // R3: accepted write below the limit adds one
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (dinWr && !full && fillCnt != CNT_MAX) |=> fillCnt == $past(fillCnt) + 1'b1);
  // R5: a locked bank keeps its count
  a_r5_locked_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dinWr && full) |=> $stable(fillCnt));
  // R5: the flag only stands at a complete fill
  a_r5_full_at_depth: assert property (@(posedge clk) disable iff (!rstN)
    full |-> fillCnt == CNT_MAX);
  // R4: a clear request empties the counter
  a_r4_clear: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrData[BIT_CLR]) |=> (fillCnt == '0 && !full));
  // R3: count never exceeds the depth
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= CNT_MAX);
endmodule

// File: rtl/cfg_shift_array.sv
module cfg_shift_array
  import cfg_shift_pkg::*;
#(
  parameter int DEPTH = 54,
  parameter int WIDTH = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [1:0]             wrAddr,
  input  logic [WIDTH-1:0]       wrData,
  input  logic                   rdEn,
  input  logic [1:0]             rdAddr,
  output logic [WIDTH-1:0]       rdData,
  output logic [DEPTH*WIDTH-1:0] cfgOut
);
  ctrlStrobes_t     strobes;
  logic [WIDTH-1:0] dataOut;

  cfg_array_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .dataOut(dataOut), .rdData(rdData),
    .strobes(strobes)
  );

  cfg_array_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataIn(wrData),
    .dataOut(dataOut), .cfgOut(cfgOut)
  );
endmodule

// File: tb/cfg_shift_array_test.sv
module cfg_shift_array_test;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 54;
  localparam int WIDTH  = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] wrAddr = '0, rdAddr = '0;
  logic [WIDTH-1:0] wrData = '0;
  logic [WIDTH-1:0] rdData;
  logic [DEPTH*WIDTH-1:0] cfgOut;

  int tests = 0, fails = 0;
  logic [WIDTH-1:0] expQ[$];
  string tagQ[$];
  logic [WIDTH-1:0] model [DEPTH];
  logic [WIDTH-1:0] firstPass [DEPTH];

  always #(PERIOD/2) clk = ~clk;

  cfg_shift_array uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .cfgOut(cfgOut)
  );

  task automatic check(input string tag, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per read strobe
  always @(posedge clk) begin
    if (rdEn) begin
      #1;
      if (expQ.size() == 0) check("R9 queue underflow", rdData, 'x);
      else check(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  // one cycle with optional write and optional read
  task automatic cycle(input logic w, input logic [1:0] wa, input logic [WIDTH-1:0] wd,
                       input logic r, input logic [1:0] ra, input logic [WIDTH-1:0] exp,
                       input string tag);
    @(negedge clk);
    wrEn = w; wrAddr = wa; wrData = wd;
    rdEn = r; rdAddr = ra;
    if (r) begin expQ.push_back(exp); tagQ.push_back(tag); end
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  function automatic logic [WIDTH-1:0] ctrlWord(input int cnt, input logic f, input logic c, input logic e);
    return WIDTH'(cnt << 8) | {29'd0, f, c, e};
  endfunction

  task automatic checkCfg(input string tag, input logic en);
    for (int k = 0; k < DEPTH; k++)
      check(tag, cfgOut[k*WIDTH +: WIDTH], en ? model[k] : '0);
  endtask

  task automatic modelShift(input logic [WIDTH-1:0] d);
    for (int k = DEPTH-1; k > 0; k--) model[k] = model[k-1];
    model[0] = d;
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < DEPTH; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    cycle(0, 0, 0, 1, 2'd0, 32'h0, "R1 ctrl after reset");
    cycle(0, 0, 0, 1, 2'd2, 32'h0, "R1 dout after reset");
    check("R1 cfgOut low word after reset", cfgOut[WIDTH-1:0], '0);

    // R4 clear then first pass
    cycle(1, 2'd0, 32'h2, 0, 0, 0, "");
    for (int i = 0; i < DEPTH; i++) begin
      firstPass[i] = 32'hA500_0000 + i * 32'h0101_0013;
      if (i == DEPTH-1)  // write and read in one cycle: pre-write state, R9
        cycle(1, 2'd1, firstPass[i], 1, 2'd0, ctrlWord(53, 0, 1, 0), "R9 same-cycle read count 53");
      else
        cycle(1, 2'd1, firstPass[i], 0, 0, 0, "");
      modelShift(firstPass[i]);
      if (i == 9) cycle(0, 0, 0, 1, 2'd0, ctrlWord(10, 0, 1, 0), "R3 count after 10 writes");
    end
    cycle(0, 0, 0, 1, 2'd0, ctrlWord(54, 1, 1, 0), "R5 full at 54");
    cycle(0, 0, 0, 1, 2'd2, 32'h0, "R8 dout after first pass");
    checkCfg("R7 disabled outputs zero", 1'b0);

    // R5 locked write ignored
    cycle(1, 2'd1, 32'hDEAD_BEEF, 0, 0, 0, "");
    cycle(0, 0, 0, 1, 2'd0, ctrlWord(54, 1, 1, 0), "R5 locked count unchanged");
    cycle(0, 0, 0, 1, 2'd2, 32'h0, "R5 locked dout unchanged");
    cycle(0, 0, 0, 1, 2'd1, 32'h0, "R9 data-in reads zero");

    // enable with clear: R7 and R4
    cycle(1, 2'd0, 32'h3, 0, 0, 0, "");
    checkCfg("R2 R7 enabled entries", 1'b1);
    check("R2 top holds first word", cfgOut[(DEPTH-1)*WIDTH +: WIDTH], firstPass[0]);
    cycle(0, 0, 0, 1, 2'd0, ctrlWord(0, 0, 1, 1), "R4 cleared count");

    // second pass readback R8
    for (int i = 0; i < DEPTH; i++) begin
      cycle(1, 2'd1, ~firstPass[i], 0, 0, 0, "");
      modelShift(~firstPass[i]);
      cycle(0, 0, 0, 1, 2'd2, firstPass[i], "R8 readback order");
    end
    cycle(0, 0, 0, 1, 2'd0, ctrlWord(54, 1, 1, 1), "R5 full after second pass");

    // R6 unlock without clear
    cycle(1, 2'd0, 32'h1, 0, 0, 0, "");
    cycle(0, 0, 0, 1, 2'd0, ctrlWord(54, 0, 0, 1), "R6 unlock keeps count");
    cycle(1, 2'd1, 32'h1234_5678, 0, 0, 0, "");
    modelShift(32'h1234_5678);
    cycle(0, 0, 0, 1, 2'd0, ctrlWord(54, 0, 0, 1), "R6 R3 saturated, not full");
    cycle(0, 0, 0, 1, 2'd2, ~firstPass[0], "R6 R8 dout after unlocked write");
    check("R6 R2 new word at position 1", cfgOut[WIDTH-1:0], 32'h1234_5678);
    checkCfg("R2 chain after unlocked write", 1'b1);

    // disable: R7
    cycle(1, 2'd0, 32'h0, 0, 0, 0, "");
    checkCfg("R7 disabled again", 1'b0);
    cycle(0, 0, 0, 1, 2'd3, 32'h0, "R9 unused address reads zero");

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule